// File: doc/BRIEF.md
# Three-Phase Teaching Processor Core

A small multicycle processor that executes a program held in an internal 256-word by 16-bit memory. Program and data share this memory. Each instruction is a single 16-bit word made of four 4-bit fields. The most significant field selects the operation. The other three fields name registers, or two of them are joined into an 8-bit memory address.

Every instruction passes through the same phases in turn:
1. The fetch phase presents the program counter to the memory.
2. One cycle later the returned word is latched into the instruction register and the program counter advances by one.
3. The decode phase reads the operands.
4. The execute phase writes the result.

One instruction therefore takes exactly four clock cycles, and there is no overlap between instructions. The core runs from address 0x00 after reset until it executes a halt, and then raises a flag.

A test environment fills memory through a preload port while reset is held. It observes results through a combinational debug port that reads any register or any memory word. Input and output devices are modelled as ordinary memory words reached by loads and stores.

Top module: `edu_cpu_top`

## Requirements
- R1: While rst_ni is low, the program counter, instruction register, all sixteen registers and halted_o are zero, and a pre_we_i pulse writes pre_data_i to memory at pre_addr_i. While rst_ni is high, pre_we_i has no effect on memory.
- R2: Instruction encoding is op = bits 15:12, a = bits 11:8, b = bits 7:4, c = bits 3:0. Each instruction takes exactly four clocks, so a program of N instructions ending in halt raises halted_o on the 4N-th rising edge after reset is released.
- R3: Opcode 1 loads M[{b,c}] into register a. Opcode 2 stores register a into M[{b,c}]. Addresses are unsigned 8-bit values.
- R4: Opcode 3 writes register b plus register c into register a, in two's complement and modulo 2^16.
- R5: Opcode 5 copies register b into register a. Opcode 6 writes the bitwise inverse of register b. Opcodes 7, 8 and 9 write register b AND, OR and XOR register c into register a.
- R6: Opcode A increments register a and opcode B decrements register a, both wrapping modulo 2^16.
- R7: Opcode C rotates register a by b bit positions. Bit 0 of field c selects the direction: 0 rotates left and 1 rotates right.
- R8: Opcode D sets the program counter to {b,c} when register 0 is nonzero. Otherwise execution continues at the next word.
- R9: Opcodes 4, E and F change no register and no memory word.
- R10: Opcode 0 raises halted_o. The flag then stays high until reset, and no further instruction changes a register or memory.
- R11: The program 0x1040, 0x1141, 0x3201, 0x2242, 0x0000, run with 0x00A1 at 0x40 and 0x00FE at 0x41, leaves 0x019F at 0x42.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pre_we_i | input | 1 | Preload write strobe, honoured only in reset |
| pre_addr_i | input | 8 | Preload word address |
| pre_data_i | input | 16 | Preload data |
| halted_o | output | 1 | High once a halt has executed |
| dbg_reg_sel_i | input | 4 | Debug register index |
| dbg_reg_o | output | 16 | Contents of the selected register |
| dbg_mem_addr_i | input | 8 | Debug memory address |
| dbg_mem_o | output | 16 | Contents of the addressed memory word |

## Verification
The hardest behaviour to observe is the phase timing: the program counter and phase sequencer are not visible at the ports. The bench counts clock edges from reset release until halted_o rises and compares the count with four cycles per instruction. It does this for programs that include no-operation codes and taken and untaken jumps, so a phase that is skipped or repeated shows up as a wrong count. A jump is checked by which of two load instructions actually ran. Writes that must be ignored are checked through the debug port: a preload strobe issued after reset release, and a store placed after the halt.

// File: rtl/edu_cpu_pkg.sv
package edu_cpu_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned NREG   = 16;
  localparam int unsigned FLD_W  = 4;
  localparam int unsigned RSEL_W = $clog2(NREG);

  localparam logic [FLD_W-1:0] OP_HALT  = 4'h0;
  localparam logic [FLD_W-1:0] OP_LOAD  = 4'h1;
  localparam logic [FLD_W-1:0] OP_STORE = 4'h2;
  localparam logic [FLD_W-1:0] OP_ADD   = 4'h3;
  localparam logic [FLD_W-1:0] OP_MOVE  = 4'h5;
  localparam logic [FLD_W-1:0] OP_NOT   = 4'h6;
  localparam logic [FLD_W-1:0] OP_AND   = 4'h7;
  localparam logic [FLD_W-1:0] OP_OR    = 4'h8;
  localparam logic [FLD_W-1:0] OP_XOR   = 4'h9;
  localparam logic [FLD_W-1:0] OP_INC   = 4'hA;
  localparam logic [FLD_W-1:0] OP_DEC   = 4'hB;
  localparam logic [FLD_W-1:0] OP_ROT   = 4'hC;
  localparam logic [FLD_W-1:0] OP_JNZ   = 4'hD;

  typedef enum logic [2:0] {
    PH_FETCH, PH_LATCH, PH_DECODE, PH_EXEC, PH_STOP
  } phase_e;
endpackage

// File: rtl/edu_cpu_mem.sv
module edu_cpu_mem #(
  parameter int unsigned DW = 16,
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  input  logic [AW-1:0] dbg_addr_i,
  output logic [DW-1:0] dbg_data_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end

  assign dbg_data_o = mem_q[dbg_addr_i];
endmodule

// File: rtl/edu_cpu_regfile.sv
module edu_cpu_regfile #(
  parameter int unsigned DW   = 16,
  parameter int unsigned NREG = 16,
  localparam int unsigned SW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [SW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [SW-1:0] ra_a_i,
  input  logic [SW-1:0] ra_b_i,
  input  logic [SW-1:0] ra_c_i,
  input  logic [SW-1:0] ra_dbg_i,
  output logic [DW-1:0] rd_a_o,
  output logic [DW-1:0] rd_b_o,
  output logic [DW-1:0] rd_c_o,
  output logic [DW-1:0] rd_dbg_o,
  output logic [DW-1:0] rd_zero_o
);
  logic [DW-1:0] rf_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) rf_q[i] <= '0;
    end else if (we_i) begin
      rf_q[waddr_i] <= wdata_i;
    end
  end

  assign rd_a_o    = rf_q[ra_a_i];
  assign rd_b_o    = rf_q[ra_b_i];
  assign rd_c_o    = rf_q[ra_c_i];
  assign rd_dbg_o  = rf_q[ra_dbg_i];
  assign rd_zero_o = rf_q[0];
endmodule

// File: rtl/edu_cpu_alu.sv
module edu_cpu_alu
  import edu_cpu_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic [FLD_W-1:0] op_i,
  input  logic [DW-1:0]    opd_i,   // register named by field a
  input  logic [DW-1:0]    ops_i,   // register named by field b
  input  logic [DW-1:0]    opt_i,   // register named by field c
  input  logic [FLD_W-1:0] amt_i,
  input  logic             dir_right_i,
  output logic [DW-1:0]    res_o,
  output logic             wb_o
);
  logic [2*DW-1:0] rot_l, rot_r;

  always_comb begin
    rot_l = {opd_i, opd_i} << amt_i;
    rot_r = {opd_i, opd_i} >> amt_i;
  end

  always_comb begin
    res_o = '0;
    wb_o  = 1'b1;
    unique case (op_i)
      OP_ADD:  res_o = ops_i + opt_i;
      OP_MOVE: res_o = ops_i;
      OP_NOT:  res_o = ~ops_i;
      OP_AND:  res_o = ops_i & opt_i;
      OP_OR:   res_o = ops_i | opt_i;
      OP_XOR:  res_o = ops_i ^ opt_i;
      OP_INC:  res_o = opd_i + 1'b1;
      OP_DEC:  res_o = opd_i - 1'b1;
      OP_ROT:  res_o = dir_right_i ? rot_r[DW-1:0] : rot_l[2*DW-1:DW];
      default: wb_o  = 1'b0;
    endcase
  end
endmodule

// File: rtl/edu_cpu_top.sv
module edu_cpu_top
  import edu_cpu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pre_we_i,
  input  logic [ADDR_W-1:0] pre_addr_i,
  input  logic [DATA_W-1:0] pre_data_i,
  output logic              halted_o,
  input  logic [RSEL_W-1:0] dbg_reg_sel_i,
  output logic [DATA_W-1:0] dbg_reg_o,
  input  logic [ADDR_W-1:0] dbg_mem_addr_i,
  output logic [DATA_W-1:0] dbg_mem_o
);
  phase_e            state_q;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] ir_q;
  logic              halted_q;
  logic [DATA_W-1:0] opd_q, ops_q, opt_q;

  logic [FLD_W-1:0]  op, fa, fb, fc;
  logic [ADDR_W-1:0] ir_addr;
  assign op      = ir_q[4*FLD_W-1:3*FLD_W];
  assign fa      = ir_q[3*FLD_W-1:2*FLD_W];
  assign fb      = ir_q[2*FLD_W-1:FLD_W];
  assign fc      = ir_q[FLD_W-1:0];
  assign ir_addr = ir_q[ADDR_W-1:0];

  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr, mem_raddr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;
  logic              core_mem_we;

  assign core_mem_we = (state_q == PH_EXEC) && (op == OP_STORE);
  assign mem_we      = rst_ni ? core_mem_we : pre_we_i;
  assign mem_waddr   = rst_ni ? ir_addr : pre_addr_i;
  assign mem_wdata   = rst_ni ? opd_q : pre_data_i;
  assign mem_raddr   = (state_q == PH_FETCH) ? pc_q : ir_addr;

  edu_cpu_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
    .clk_i      (clk_i),
    .we_i       (mem_we),
    .waddr_i    (mem_waddr),
    .wdata_i    (mem_wdata),
    .raddr_i    (mem_raddr),
    .rdata_o    (mem_rdata),
    .dbg_addr_i (dbg_mem_addr_i),
    .dbg_data_o (dbg_mem_o)
  );

  logic              rf_we;
  logic [DATA_W-1:0] rf_wdata, rd_a, rd_b, rd_c, rd_zero;
  logic [DATA_W-1:0] alu_res;
  logic              alu_wb;

  edu_cpu_alu #(.DW(DATA_W)) u_alu (
    .op_i        (op),
    .opd_i       (opd_q),
    .ops_i       (ops_q),
    .opt_i       (opt_q),
    .amt_i       (fb),
    .dir_right_i (fc[0]),
    .res_o       (alu_res),
    .wb_o        (alu_wb)
  );

  assign rf_we    = (state_q == PH_EXEC) && ((op == OP_LOAD) || alu_wb);
  assign rf_wdata = (op == OP_LOAD) ? mem_rdata : alu_res;

  edu_cpu_regfile #(.DW(DATA_W), .NREG(NREG)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (rf_we),
    .waddr_i   (fa),
    .wdata_i   (rf_wdata),
    .ra_a_i    (fa),
    .ra_b_i    (fb),
    .ra_c_i    (fc),
    .ra_dbg_i  (dbg_reg_sel_i),
    .rd_a_o    (rd_a),
    .rd_b_o    (rd_b),
    .rd_c_o    (rd_c),
    .rd_dbg_o  (dbg_reg_o),
    .rd_zero_o (rd_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= PH_FETCH;
      pc_q     <= '0;
      ir_q     <= '0;
      halted_q <= 1'b0;
      opd_q    <= '0;
      ops_q    <= '0;
      opt_q    <= '0;
    end else begin
      unique case (state_q)
        PH_FETCH: state_q <= PH_LATCH;   // memory read in flight
        PH_LATCH: begin
          ir_q    <= mem_rdata;
          pc_q    <= pc_q + 1'b1;
          state_q <= PH_DECODE;
        end
        PH_DECODE: begin
          opd_q   <= rd_a;
          ops_q   <= rd_b;
          opt_q   <= rd_c;
          state_q <= PH_EXEC;            // load data arrives during exec
        end
        PH_EXEC: begin
          if (op == OP_HALT) begin
            halted_q <= 1'b1;
            state_q  <= PH_STOP;
          end else begin
            if ((op == OP_JNZ) && (rd_zero != '0)) pc_q <= ir_addr;
            state_q <= PH_FETCH;
          end
        end
        default: state_q <= PH_STOP;
      endcase
    end
  end

  assign halted_o = halted_q;

  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == PH_LATCH |=> pc_q == $past(pc_q) + 1'b1); // R2
  AST_PHASE_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == PH_DECODE |=> state_q == PH_EXEC); // R2
  AST_JUMP_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_EXEC && op == OP_JNZ && rd_zero != '0) |=> pc_q == $past(ir_addr)); // R8
  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_q |=> halted_q && $stable(pc_q)); // R10
  AST_HALT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_q |-> !rf_we && !core_mem_we); // R10
endmodule

// File: tb/edu_cpu_top_tb.sv
module edu_cpu_top_tb;
  localparam int CLK_P = 10;
  localparam int WDOG_CYC = 100000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pre_we_i = 1'b0;
  logic [7:0]  pre_addr_i = '0;
  logic [15:0] pre_data_i = '0;
  logic        halted_o;
  logic [3:0]  dbg_reg_sel_i = '0;
  logic [15:0] dbg_reg_o;
  logic [7:0]  dbg_mem_addr_i = '0;
  logic [15:0] dbg_mem_o;

  int total = 0;
  int bad = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  edu_cpu_top u_dut (
    .clk_i, .rst_ni, .pre_we_i, .pre_addr_i, .pre_data_i, .halted_o,
    .dbg_reg_sel_i, .dbg_reg_o, .dbg_mem_addr_i, .dbg_mem_o
  );

  function automatic logic [15:0] enc(input logic [3:0] op, input logic [3:0] a,
                                      input logic [3:0] b, input logic [3:0] c);
    return {op, a, b, c};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_reg(input string req, input logic [3:0] r, input logic [15:0] exp);
    dbg_reg_sel_i = r;
    #1;
    chk(req, {16'h0, dbg_reg_o}, {16'h0, exp});
  endtask

  task automatic chk_mem(input string req, input logic [7:0] a, input logic [15:0] exp);
    dbg_mem_addr_i = a;
    #1;
    chk(req, {16'h0, dbg_mem_o}, {16'h0, exp});
  endtask

  task automatic enter_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
  endtask

  task automatic pl(input logic [7:0] a, input logic [15:0] d);
    pre_we_i = 1'b1;
    pre_addr_i = a;
    pre_data_i = d;
    @(negedge clk_i);
    pre_we_i = 1'b0;
  endtask

  task automatic run(output int n);
    n = 0;
    rst_ni = 1'b1;
    while (n < 2000) begin
      @(posedge clk_i);
      @(negedge clk_i);
      n++;
      if (halted_o) break;
    end
  endtask

  task automatic t_reference();
    int n;
    enter_reset();
    pl(8'h00, 16'h1040);
    pl(8'h01, 16'h1141);
    pl(8'h02, 16'h3201);
    pl(8'h03, 16'h2242);
    pl(8'h04, 16'h0000);
    pl(8'h05, enc(4'h2, 4'h0, 4'h4, 4'h3)); // store after halt
    pl(8'h40, 16'h00A1);
    pl(8'h41, 16'h00FE);
    pl(8'h42, 16'h0000);
    pl(8'h43, 16'h1234);
    pl(8'h50, 16'h0BAD);
    run(n);
    chk("R2 cycles for 5 instructions", n, 20);
    chk_mem("R11 sum at 0x42", 8'h42, 16'h019F);
    chk_reg("R3 load into R1", 4'h1, 16'h00FE);
    chk_reg("R4 add into R2", 4'h2, 16'h019F);
    // preload strobe while running must be ignored
    pre_we_i = 1'b1; pre_addr_i = 8'h50; pre_data_i = 16'hDEAD;
    @(negedge clk_i);
    pre_we_i = 1'b0;
    repeat (10) @(negedge clk_i);
    chk_mem("R1 preload ignored out of reset", 8'h50, 16'h0BAD);
    chk("R10 halted stays high", {31'h0, halted_o}, 1);
    chk_mem("R10 no store after halt", 8'h43, 16'h1234);
  endtask

  task automatic t_reset();
    enter_reset();
    @(negedge clk_i);
    chk("R1 halted clear in reset", {31'h0, halted_o}, 0);
    for (int r = 0; r < 16; r++) chk_reg("R1 register cleared", r[3:0], 16'h0000);
  endtask

  task automatic t_arith();
    int n;
    enter_reset();
    pl(8'h00, enc(4'h1, 4'h1, 4'h4, 4'h0)); // R1=7FFF
    pl(8'h01, enc(4'h1, 4'h2, 4'h4, 4'h1)); // R2=0001
    pl(8'h02, enc(4'h1, 4'h3, 4'h4, 4'h2)); // R3=FFFF
    pl(8'h03, enc(4'h3, 4'h4, 4'h1, 4'h2)); // R4=R1+R2
    pl(8'h04, enc(4'h3, 4'h5, 4'h3, 4'h2)); // R5=R3+R2
    pl(8'h05, enc(4'hA, 4'h3, 4'h0, 4'h0)); // R3++
    pl(8'h06, enc(4'hB, 4'h6, 4'h0, 4'h0)); // R6--
    pl(8'h07, enc(4'hB, 4'h1, 4'h0, 4'h0)); // R1--
    pl(8'h08, 16'h0000);
    pl(8'h40, 16'h7FFF);
    pl(8'h41, 16'h0001);
    pl(8'h42, 16'hFFFF);
    run(n);
    chk("R2 cycles for 9 instructions", n, 36);
    chk_reg("R4 add overflow to 8000", 4'h4, 16'h8000);
    chk_reg("R4 add wrap to 0", 4'h5, 16'h0000);
    chk_reg("R6 inc wraps FFFF to 0", 4'h3, 16'h0000);
    chk_reg("R6 dec wraps 0 to FFFF", 4'h6, 16'hFFFF);
    chk_reg("R6 dec 7FFF", 4'h1, 16'h7FFE);
  endtask

  task automatic t_logic();
    int n;
    enter_reset();
    pl(8'h00, enc(4'h1, 4'h1, 4'h4, 4'h0));
    pl(8'h01, enc(4'h1, 4'h2, 4'h4, 4'h1));
    pl(8'h02, enc(4'h5, 4'h3, 4'h1, 4'h0));
    pl(8'h03, enc(4'h6, 4'h4, 4'h1, 4'h0));
    pl(8'h04, enc(4'h7, 4'h5, 4'h1, 4'h2));
    pl(8'h05, enc(4'h8, 4'h6, 4'h1, 4'h2));
    pl(8'h06, enc(4'h9, 4'h7, 4'h1, 4'h2));
    pl(8'h07, 16'h0000);
    pl(8'h40, 16'hF0F0);
    pl(8'h41, 16'h3C3C);
    run(n);
    chk_reg("R5 move", 4'h3, 16'hF0F0);
    chk_reg("R5 not", 4'h4, 16'h0F0F);
    chk_reg("R5 and", 4'h5, 16'h3030);
    chk_reg("R5 or", 4'h6, 16'hFCFC);
    chk_reg("R5 xor", 4'h7, 16'hCCCC);
  endtask

  task automatic t_rotate();
    int n;
    enter_reset();
    pl(8'h00, enc(4'h1, 4'h1, 4'h4, 4'h0));
    pl(8'h01, enc(4'h5, 4'h2, 4'h1, 4'h0));
    pl(8'h02, enc(4'h5, 4'h3, 4'h1, 4'h0));
    pl(8'h03, enc(4'h5, 4'h4, 4'h1, 4'h0));
    pl(8'h04, enc(4'hC, 4'h2, 4'h4, 4'h0)); // left 4
    pl(8'h05, enc(4'hC, 4'h3, 4'h4, 4'h1)); // right 4
    pl(8'h06, enc(4'hC, 4'h4, 4'h0, 4'h0)); // by 0
    pl(8'h07, enc(4'hC, 4'h1, 4'hF, 4'h1)); // right 15
    pl(8'h08, 16'h0000);
    pl(8'h40, 16'h8001);
    run(n);
    chk_reg("R7 rotate left 4", 4'h2, 16'h0018);
    chk_reg("R7 rotate right 4", 4'h3, 16'h1800);
    chk_reg("R7 rotate by 0", 4'h4, 16'h8001);
    chk_reg("R7 rotate right 15", 4'h1, 16'h0003);
  endtask

  task automatic t_jump(input logic [15:0] r0v);
    int n;
    logic taken;
    taken = (r0v != 0);
    enter_reset();
    pl(8'h00, enc(4'h1, 4'h0, 4'h4, 4'h0));
    pl(8'h01, enc(4'hD, 4'h0, 4'h0, 4'h4));
    pl(8'h02, enc(4'h1, 4'h1, 4'h4, 4'h1));
    pl(8'h03, 16'h0000);
    pl(8'h04, enc(4'h1, 4'h2, 4'h4, 4'h1));
    pl(8'h05, 16'h0000);
    pl(8'h40, r0v);
    pl(8'h41, 16'h5555);
    run(n);
    chk("R8 jump cycle count", n, 16);
    chk_reg("R8 fall-through load", 4'h1, taken ? 16'h0000 : 16'h5555);
    chk_reg("R8 target load", 4'h2, taken ? 16'h5555 : 16'h0000);
  endtask

  task automatic t_nop();
    int n;
    enter_reset();
    pl(8'h00, enc(4'h1, 4'h1, 4'h4, 4'h0));
    pl(8'h01, 16'h4123);
    pl(8'h02, 16'hE123);
    pl(8'h03, 16'hF1FF);
    pl(8'h04, enc(4'h2, 4'h1, 4'h4, 4'h1));
    pl(8'h05, 16'h0000);
    pl(8'h23, 16'h1111);
    pl(8'hFF, 16'h2222);
    pl(8'h40, 16'hABCD);
    pl(8'h41, 16'h0000);
    run(n);
    chk("R9 no-ops take four cycles each", n, 24);
    chk_reg("R9 R1 untouched", 4'h1, 16'hABCD);
    chk_reg("R9 R2 untouched", 4'h2, 16'h0000);
    chk_reg("R9 R3 untouched", 4'h3, 16'h0000);
    chk_mem("R9 mem 0x23 untouched", 8'h23, 16'h1111);
    chk_mem("R9 mem 0xFF untouched", 8'hFF, 16'h2222);
    chk_mem("R3 store after no-ops", 8'h41, 16'hABCD);
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    t_reference();
    t_reset();
    t_arith();
    t_logic();
    t_rotate();
    t_jump(16'h0001);
    t_jump(16'h0000);
    t_nop();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule